// File: doc/BRIEF.md
# Shift-Immediate Instruction Decoder

This block examines one 32-bit RV32I instruction word per cycle and recognises the three shift-by-constant instructions: logical left, logical right and arithmetic right. When the word is one of them, the block reports which shift it is, the constant shift amount, the source and destination register indices, and the shifted value of a supplied source operand. All outputs are registered, so a result appears one clock after the instruction is presented.

Within the immediate-ALU opcode, the two shift funct3 codes admit only specific upper-immediate patterns. Any other pattern under those codes is flagged as illegal and never produces a write. Words from other opcodes or funct3 codes are passed over quietly: no write, no illegal flag.

The shifter works in a single direction. A left shift reverses the operand, shifts right through a chain of power-of-two stages with a zero fill, and reverses the result back.

Top module: `shift_imm_decoder`

## Requirements
- R1: An input word with opcode bits [6:0] = 0010011, funct3 bits [14:12] = 001 and bits [31:25] = 0000000 is a legal left shift. The block reports kindOut = 1 and wrEnOut = 1.
- R2: With opcode 0010011 and funct3 = 101, bits [31:25] = 0000000 give a legal logical right shift (kindOut = 2). Bits [31:25] = 0100000 give a legal arithmetic right shift (kindOut = 3). Both set wrEnOut = 1.
- R3: shamtOut carries bits [24:20], srcRegOut carries bits [19:15] and dstRegOut carries bits [11:7] of every accepted word, whatever that word decodes to.
- R4: The left shift moves the operand toward bit 31 and fills the vacated low bits with zeros.
- R5: The logical right shift moves the operand toward bit 0 and fills the vacated high bits with zeros.
- R6: The arithmetic right shift fills every vacated high bit with the operand's original bit 31.
- R7: A shift amount of zero returns the operand unchanged for all three kinds.
- R8: With opcode 0010011 and funct3 001 or 101, any bits [31:25] other than the legal pattern for that funct3 give illegalOut = 1, wrEnOut = 0, kindOut = 0 and resultOut = 0.
- R9: A word with any other opcode, or any other funct3, gives illegalOut = 0, wrEnOut = 0, kindOut = 0 and resultOut = 0.
- R10: validOut equals validIn from the previous clock. Its outputs describe the word that was accepted on that clock.
- R11: In a cycle with validIn low, the block does the following on the next clock:
  - resultOut, kindOut, shamtOut, srcRegOut and dstRegOut keep their previous values.
  - wrEnOut and illegalOut go to 0.
- R12: While reset is asserted, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| validIn | input | 1 | Instruction word and operand are present this cycle |
| instrIn | input | 32 | Instruction word |
| operandIn | input | 32 | Value read from the source register |
| validOut | output | 1 | Registered outputs hold a new result |
| wrEnOut | output | 1 | Legal shift; result should be written to the destination |
| illegalOut | output | 1 | Shift funct3 with a forbidden upper-immediate pattern |
| kindOut | output | 2 | 0 none, 1 left logical, 2 right logical, 3 right arithmetic |
| shamtOut | output | 5 | Shift amount field |
| srcRegOut | output | 5 | Source register index |
| dstRegOut | output | 5 | Destination register index |
| resultOut | output | 32 | Shifted operand, or 0 when not a legal shift |

## Verification
The assertions assume the following about the inputs:
- validIn, instrIn and operandIn are driven to known values from reset onward.
- They change only away from the rising edge, so each word is sampled exactly once.

The bench follows this by driving on the falling edge and holding the inputs for a full cycle. It mixes in bubble cycles that carry deliberately unrelated instruction words and operands, which confirms that a bubble disturbs nothing.

// File: rtl/shimm_pkg.sv
package shimm_pkg;

  // Kind code seen on kindOut
  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_SLL  = 2'd1,
    KIND_SRL  = 2'd2,
    KIND_SRA  = 2'd3
  } shiftKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic       load;
    logic       legal;
    logic       illegal;
    shiftKind_e kind;
  } ctrlStrobes_t;

  localparam logic [6:0] OPC_OPIMM   = 7'b0010011;
  localparam logic [2:0] F3_LEFT     = 3'b001;
  localparam logic [2:0] F3_RIGHT    = 3'b101;
  localparam logic [6:0] UP_LOGICAL  = 7'b0000000;
  localparam logic [6:0] UP_ARITH    = 7'b0100000;

endpackage

// File: rtl/shimm_ctrl.sv
module shimm_ctrl
  import shimm_pkg::*;
(
  input  logic         validIn,
  input  logic [6:0]   opcode,
  input  logic [2:0]   funct3,
  input  logic [6:0]   upperImm,
  output ctrlStrobes_t strobes
);

  logic       isOpImm;
  logic       legalC;
  logic       illegalC;
  shiftKind_e kindC;

  assign isOpImm = (opcode == OPC_OPIMM);

  always_comb begin
    kindC    = KIND_NONE;
    legalC   = 1'b0;
    illegalC = 1'b0;
    if (isOpImm) begin
      unique case (funct3)
        F3_LEFT: begin
          if (upperImm == UP_LOGICAL) begin
            kindC  = KIND_SLL;
            legalC = 1'b1;
          end else begin
            illegalC = 1'b1;
          end
        end
        F3_RIGHT: begin
          if (upperImm == UP_LOGICAL) begin
            kindC  = KIND_SRL;
            legalC = 1'b1;
          end else if (upperImm == UP_ARITH) begin
            kindC  = KIND_SRA;
            legalC = 1'b1;
          end else begin
            illegalC = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign strobes.load    = validIn;
  assign strobes.legal   = legalC;
  assign strobes.illegal = illegalC;
  assign strobes.kind    = kindC;

endmodule

// File: rtl/shimm_dp.sv
module shimm_dp
  import shimm_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  localparam int unsigned SHAMT_W = $clog2(XLEN),
  localparam int unsigned REG_W = 5
)(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobes_t       strobes,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic [REG_W-1:0]   srcReg,
  input  logic [REG_W-1:0]   dstReg,
  input  logic [XLEN-1:0]    operand,
  output logic               validOut,
  output logic               wrEnOut,
  output logic               illegalOut,
  output logic [1:0]         kindOut,
  output logic [SHAMT_W-1:0] shamtOut,
  output logic [REG_W-1:0]   srcRegOut,
  output logic [REG_W-1:0]   dstRegOut,
  output logic [XLEN-1:0]    resultOut
);

  localparam int unsigned STAGES = SHAMT_W;

  logic            isLeft;
  logic            fillBit;
  logic [XLEN-1:0] preRev;
  logic [XLEN-1:0] postRev;
  logic [XLEN-1:0] shiftRes;
  logic [XLEN-1:0] stageVal [0:STAGES];

  assign isLeft  = (strobes.kind == KIND_SLL);
  assign fillBit = (strobes.kind == KIND_SRA) & operand[XLEN-1];

  // Mirror the operand so every kind runs as a right shift
  for (genvar b = 0; b < XLEN; b++) begin : g_preRev
    assign preRev[b] = isLeft ? operand[XLEN-1-b] : operand[b];
  end

  assign stageVal[0] = preRev;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    localparam int unsigned STEP = 1 << s;
    assign stageVal[s+1] = shamt[s]
      ? { {STEP{fillBit}}, stageVal[s][XLEN-1:STEP] }
      : stageVal[s];
  end

  for (genvar b = 0; b < XLEN; b++) begin : g_postRev
    assign postRev[b] = isLeft ? stageVal[STAGES][XLEN-1-b] : stageVal[STAGES][b];
  end

  assign shiftRes = strobes.legal ? postRev : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validOut   <= 1'b0;
      wrEnOut    <= 1'b0;
      illegalOut <= 1'b0;
      kindOut    <= 2'd0;
      shamtOut   <= '0;
      srcRegOut  <= '0;
      dstRegOut  <= '0;
      resultOut  <= '0;
    end else begin
      validOut   <= strobes.load;
      wrEnOut    <= strobes.load & strobes.legal;
      illegalOut <= strobes.load & strobes.illegal;
      if (strobes.load) begin
        kindOut   <= strobes.kind;
        shamtOut  <= shamt;
        srcRegOut <= srcReg;
        dstRegOut <= dstReg;
        resultOut <= shiftRes;
      end
    end
  end

  AST_SLL_LOW_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.kind == KIND_SLL && shamt != '0) |-> !shiftRes[0]);          // R4
  AST_SRL_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.kind == KIND_SRL && shamt != '0) |-> !shiftRes[XLEN-1]);     // R5
  AST_SRA_SIGN_FILL: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.kind == KIND_SRA) |-> (shiftRes[XLEN-1] == operand[XLEN-1])); // R6
  AST_ZERO_AMOUNT_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.legal && shamt == '0) |-> (shiftRes == operand));           // R7

endmodule

// File: rtl/shift_imm_decoder.sv
module shift_imm_decoder
  import shimm_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        validIn,
  input  logic [31:0] instrIn,
  input  logic [31:0] operandIn,
  output logic        validOut,
  output logic        wrEnOut,
  output logic        illegalOut,
  output logic [1:0]  kindOut,
  output logic [4:0]  shamtOut,
  output logic [4:0]  srcRegOut,
  output logic [4:0]  dstRegOut,
  output logic [31:0] resultOut
);

  ctrlStrobes_t strobes;

  shimm_ctrl u_ctrl (
    .validIn  (validIn),
    .opcode   (instrIn[6:0]),
    .funct3   (instrIn[14:12]),
    .upperImm (instrIn[31:25]),
    .strobes  (strobes)
  );

  shimm_dp #(.XLEN(32)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .shamt      (instrIn[24:20]),
    .srcReg     (instrIn[19:15]),
    .dstReg     (instrIn[11:7]),
    .operand    (operandIn),
    .validOut   (validOut),
    .wrEnOut    (wrEnOut),
    .illegalOut (illegalOut),
    .kindOut    (kindOut),
    .shamtOut   (shamtOut),
    .srcRegOut  (srcRegOut),
    .dstRegOut  (dstRegOut),
    .resultOut  (resultOut)
  );

  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    illegalOut |-> (!wrEnOut && kindOut == 2'd0 && resultOut == '0));     // R8
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    validIn |=> validOut);                                                // R10
  AST_BUBBLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> !validOut);                                              // R10
  AST_BUBBLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !validIn |=> ($stable(resultOut) && $stable(kindOut) && !wrEnOut && !illegalOut)); // R11
  AST_WRITE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    wrEnOut |-> validOut);                                                // R10

endmodule

// File: tb/sim_shift_imm_decoder.sv
`timescale 1ns/1ps
module sim_shift_imm_decoder;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        validIn = 1'b0;
  logic [31:0] instrIn = '0;
  logic [31:0] operandIn = '0;
  logic        validOut, wrEnOut, illegalOut;
  logic [1:0]  kindOut;
  logic [4:0]  shamtOut, srcRegOut, dstRegOut;
  logic [31:0] resultOut;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic        wrEn;
    logic        illegal;
    logic [1:0]  kind;
    logic [4:0]  shamt;
    logic [4:0]  rs1;
    logic [4:0]  rd;
    logic [31:0] result;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t lastSeen;
  logic     seenAny = 1'b0;

  always #2.5 clk = ~clk;

  shift_imm_decoder u0 (
    .clk(clk), .rstN(rstN), .validIn(validIn), .instrIn(instrIn),
    .operandIn(operandIn), .validOut(validOut), .wrEnOut(wrEnOut),
    .illegalOut(illegalOut), .kindOut(kindOut), .shamtOut(shamtOut),
    .srcRegOut(srcRegOut), .dstRegOut(dstRegOut), .resultOut(resultOut)
  );

  function automatic logic [31:0] mk(logic [6:0] up, logic [4:0] sh, logic [4:0] rs,
                                     logic [2:0] f3, logic [4:0] rd, logic [6:0] opc);
    return {up, sh, rs, f3, rd, opc};
  endfunction

  function automatic expItem_t model(logic [31:0] ins, logic [31:0] op, string tag);
    expItem_t e;
    logic legal;
    legal     = 1'b0;
    e.illegal = 1'b0;
    e.kind    = 2'd0;
    if (ins[6:0] == 7'b0010011) begin
      if (ins[14:12] == 3'b001) begin
        if (ins[31:25] == 7'b0000000) begin legal = 1'b1; e.kind = 2'd1; end
        else e.illegal = 1'b1;
      end else if (ins[14:12] == 3'b101) begin
        if (ins[31:25] == 7'b0000000) begin legal = 1'b1; e.kind = 2'd2; end
        else if (ins[31:25] == 7'b0100000) begin legal = 1'b1; e.kind = 2'd3; end
        else e.illegal = 1'b1;
      end
    end
    e.wrEn  = legal;
    e.shamt = ins[24:20];
    e.rs1   = ins[19:15];
    e.rd    = ins[11:7];
    if (!legal) e.result = '0;
    else if (e.kind == 2'd1) e.result = op << ins[24:20];
    else if (e.kind == 2'd2) e.result = op >> ins[24:20];
    else e.result = 32'($signed(op) >>> ins[24:20]);
    e.tag = tag;
    return e;
  endfunction

  task automatic send(logic [31:0] ins, logic [31:0] op, string tag);
    @(negedge clk);
    validIn   = 1'b1;
    instrIn   = ins;
    operandIn = op;
    expQ.push_back(model(ins, op, tag));
  endtask

  task automatic bubble(logic [31:0] junkIns, logic [31:0] junkOp);
    @(negedge clk);
    validIn   = 1'b0;
    instrIn   = junkIns;
    operandIn = junkOp;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rstN) begin
      if (validOut) begin
        expItem_t e;
        checks++;
        if (expQ.size() == 0) begin
          fails++;
          $display("FAIL R10: result with no pending vector, actual validOut=1 expected 0");
        end else begin
          e = expQ.pop_front();
          if (wrEnOut !== e.wrEn || illegalOut !== e.illegal || kindOut !== e.kind ||
              shamtOut !== e.shamt || srcRegOut !== e.rs1 || dstRegOut !== e.rd ||
              resultOut !== e.result) begin
            fails++;
            $display("FAIL %s: actual we=%0b ill=%0b kind=%0d sh=%0d rs1=%0d rd=%0d res=%h expected we=%0b ill=%0b kind=%0d sh=%0d rs1=%0d rd=%0d res=%h",
              e.tag, wrEnOut, illegalOut, kindOut, shamtOut, srcRegOut, dstRegOut, resultOut,
              e.wrEn, e.illegal, e.kind, e.shamt, e.rs1, e.rd, e.result);
          end
        end
        lastSeen.kind   = kindOut;
        lastSeen.shamt  = shamtOut;
        lastSeen.rs1    = srcRegOut;
        lastSeen.rd     = dstRegOut;
        lastSeen.result = resultOut;
        seenAny = 1'b1;
      end else if (seenAny) begin
        checks++; // R11 hold during bubble
        if (wrEnOut !== 1'b0 || illegalOut !== 1'b0 || kindOut !== lastSeen.kind ||
            shamtOut !== lastSeen.shamt || srcRegOut !== lastSeen.rs1 ||
            dstRegOut !== lastSeen.rd || resultOut !== lastSeen.result) begin
          fails++;
          $display("FAIL R11: actual we=%0b ill=%0b kind=%0d res=%h expected we=0 ill=0 kind=%0d res=%h",
            wrEnOut, illegalOut, kindOut, resultOut, lastSeen.kind, lastSeen.result);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    checks++; // R12 reset state
    if (validOut !== 1'b0 || wrEnOut !== 1'b0 || illegalOut !== 1'b0 || kindOut !== 2'd0 ||
        shamtOut !== 5'd0 || srcRegOut !== 5'd0 || dstRegOut !== 5'd0 || resultOut !== 32'd0) begin
      fails++;
      $display("FAIL R12: actual valid=%0b res=%h kind=%0d expected all zero", validOut, resultOut, kindOut);
    end
    rstN = 1'b1;

    // R1 / R4 left shifts
    send(mk(7'h00, 5'd4,  5'd3, 3'b001, 5'd7,  7'b0010011), 32'h8000_00F1, "R4");
    send(mk(7'h00, 5'd31, 5'd1, 3'b001, 5'd2,  7'b0010011), 32'hFFFF_FFFF, "R1");
    // R2 / R5 logical right
    send(mk(7'h00, 5'd8,  5'd9, 3'b101, 5'd10, 7'b0010011), 32'hF0F0_1234, "R5");
    send(mk(7'h00, 5'd31, 5'd9, 3'b101, 5'd11, 7'b0010011), 32'h8000_0000, "R2");
    // R2 / R6 arithmetic right
    send(mk(7'h20, 5'd12, 5'd4, 3'b101, 5'd5,  7'b0010011), 32'h8765_4321, "R6");
    send(mk(7'h20, 5'd31, 5'd4, 3'b101, 5'd6,  7'b0010011), 32'h9000_0000, "R6");
    send(mk(7'h20, 5'd3,  5'd4, 3'b101, 5'd6,  7'b0010011), 32'h7000_00FF, "R2");
    bubble(mk(7'h00, 5'd1, 5'd1, 3'b001, 5'd1, 7'b0010011), 32'h1234_5678);
    bubble(32'hFFFF_FFFF, 32'hDEAD_BEEF);
    // R7 zero amount
    send(mk(7'h00, 5'd0, 5'd30, 3'b001, 5'd29, 7'b0010011), 32'hA5A5_5A5A, "R7");
    send(mk(7'h00, 5'd0, 5'd30, 3'b101, 5'd29, 7'b0010011), 32'hA5A5_5A5A, "R7");
    send(mk(7'h20, 5'd0, 5'd30, 3'b101, 5'd29, 7'b0010011), 32'hA5A5_5A5A, "R7");
    // R3 field extraction
    send(mk(7'h00, 5'd17, 5'd31, 3'b101, 5'd0, 7'b0010011), 32'h0000_FFFF, "R3");
    // R8 forbidden upper patterns
    send(mk(7'h20, 5'd2,  5'd1, 3'b001, 5'd3, 7'b0010011), 32'h1111_1111, "R8");
    send(mk(7'h01, 5'd2,  5'd1, 3'b101, 5'd3, 7'b0010011), 32'h1111_1111, "R8");
    send(mk(7'h40, 5'd2,  5'd1, 3'b001, 5'd3, 7'b0010011), 32'h1111_1111, "R8");
    send(mk(7'h60, 5'd2,  5'd1, 3'b101, 5'd3, 7'b0010011), 32'h1111_1111, "R8");
    bubble(32'h0, 32'h0);
    // R9 unrelated words
    send(mk(7'h00, 5'd2, 5'd1, 3'b001, 5'd3, 7'b0110011), 32'h2222_2222, "R9");
    send(mk(7'h00, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0010011), 32'h2222_2222, "R9");
    send(mk(7'h20, 5'd2, 5'd1, 3'b101, 5'd3, 7'b0110011), 32'h2222_2222, "R9");
    bubble(32'h0, 32'h0);
    // R10 back-to-back mixed stream
    lfsr = 32'hACE1_2468;
    for (int i = 0; i < 200; i++) begin
      logic [6:0] up;
      logic [2:0] f3;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      up = (lfsr[3:2] == 2'd0) ? lfsr[14:8] : (lfsr[4] ? 7'h20 : 7'h00);
      f3 = lfsr[5] ? 3'b101 : (lfsr[6] ? 3'b001 : lfsr[18:16]);
      send(mk(up, lfsr[24:20], lfsr[19:15], f3, lfsr[11:7],
              lfsr[7] ? 7'b0010011 : (lfsr[8] ? 7'b0010011 : lfsr[31:25])),
           {lfsr[15:0], lfsr[31:16]} ^ 32'h5A5A_A5A5, "R10");
      if (lfsr[9] && lfsr[10]) bubble(lfsr, ~lfsr);
    end
    bubble(32'h0, 32'h0);
    bubble(32'h0, 32'h0);
    bubble(32'h0, 32'h0);
    checks++;
    if (expQ.size() != 0) begin
      fails++;
      $display("FAIL R10: actual %0d vectors unanswered expected 0", expQ.size());
    end
    finish_run();
  end

endmodule